// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read path of a byte-alterable non-volatile memory. It decides what a host read returns. While the write controller reports that an internal programming cycle is running, a read returns a status byte in place of stored data. That byte carries two early-completion indicators. Bit 7 is the inverse of bit 7 of the byte most recently written. Bit 6 changes value from one read access to the next. All other bits are driven as zero. Once the busy flag drops, reads return the array word at the addressed location again, and bit 6 stops changing.

A host can use either indicator to learn that a write has finished. With the data-inverse method it compares bit 7 against the value it wrote. With the alternating-bit method it reads twice and compares bit 6. Both indicators switch back to array data in the same cycle that busy is released. A write that the controller refused, for example because the array is protected, never raises busy, so no status is produced for it.

Internally, an access tracker follows each read with three states:
- `ACC_IDLE`: no read in progress.
- `ACC_ARRAY`: a read while not busy.
- `ACC_POLL`: a read while busy.

Its transitions are:
- `IDLE->ARRAY`: strobes go low while not busy.
- `IDLE->POLL`: strobes go low while busy.
- `ARRAY->POLL`: busy rises during a read.
- `POLL->ARRAY`: busy falls during a read.
- `ARRAY->IDLE`: strobes released.
- `POLL->IDLE`: strobes released. This transition is the only one that inverts the alternating bit.

The output stage combines the strobes, the busy flag, the alternating bit and the two data sources into the read bus.

Top module: `wr_status_resp`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0. Otherwise `dq_oe` is 0 and `dq_out` is all zeros, which stands in for the high-impedance bus.
- R2: During a read with `busy` = 1, bit 7 of `dq_out` equals the inverse of `last_msb`.
- R3: During a read with `busy` = 1, bit 6 of `dq_out` shows the alternating bit. That bit inverts at the first rising clock edge that samples the strobes released after a read whose state was `ACC_POLL`. Each such read therefore shows the opposite bit 6 to the one before it.
- R4: During a read with `busy` = 1, bits 5 down to 0 of `dq_out` are 0.
- R5: During a read with `busy` = 0, `dq_out` equals `arr_rdata`.
- R6: If `busy` falls while a read is held, `dq_out` equals `arr_rdata` in that same cycle. The alternating bit is not inverted when that read ends.
- R7: After reset the alternating bit is 0, so the first busy read shows bit 6 = 0.
- R8: Reads with `busy` = 0 never change the alternating bit. A refused write, which leaves `busy` at 0, produces array data and no status on a following read.
- R9: Holding the strobes low across many cycles of one busy read keeps bit 6 constant. The bit advances only when the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Internal programming cycle running (from write controller) |
| last_msb | input | 1 | Bit 7 of the last byte written |
| arr_rdata | input | 8 | Array word at the addressed location |
| dq_out | output | 8 | Read data bus (zero when not driven) |
| dq_oe | output | 1 | Read bus drive enable |

## Verification
The assertions assume that `busy`, `last_msb` and the strobes change only between clock edges. They also assume that `last_msb` is stable for the whole busy interval. The stickiness check also relies on every read that must be counted spanning at least one rising edge. The stimulus drives every input on the falling clock edge and holds each read across at least one rising edge. It never releases the strobes and drops `busy` in the same cycle, so the count of inversions of the alternating bit is unambiguous. Sweeps cover all 256 values of the array word, both values of `last_msb` across many busy reads, and all four strobe combinations with busy both high and low.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_ARRAY = 2'd1,
        ACC_POLL  = 2'd2
    } acc_state_t;
endpackage

// File: rtl/sp_strobe.sv
module sp_strobe (
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_sel
);
    // a host read needs both active-low strobes asserted
    assign rd_sel = ~ce_n & ~oe_n;
endmodule

// File: rtl/sp_access_fsm.sv
module sp_access_fsm
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_sel,
    input  logic       busy,
    output acc_state_t state_q,
    output logic       toggle_q
);
    acc_state_t state_d;
    logic       end_poll;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (rd_sel && busy)       state_d = ACC_POLL;
                else if (rd_sel)          state_d = ACC_ARRAY;
            end
            ACC_ARRAY: begin
                if (!rd_sel)              state_d = ACC_IDLE;
                else if (busy)            state_d = ACC_POLL;
            end
            ACC_POLL: begin
                if (!rd_sel)              state_d = ACC_IDLE;
                else if (!busy)           state_d = ACC_ARRAY;
            end
            default:                      state_d = ACC_IDLE;
        endcase
    end

    // a busy access is over when the strobes are seen released
    assign end_poll = (state_q == ACC_POLL) && !rd_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ACC_IDLE;
            toggle_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            if (end_poll)
                toggle_q <= ~toggle_q;
        end
    end
endmodule

// File: rtl/sp_out_mux.sv
module sp_out_mux #(
    parameter int DATA_W = 8
) (
    input  logic              rd_sel,
    input  logic              busy,
    input  logic              toggle,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TGL_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] status;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_status
            if (i == POLL_BIT) begin : g_poll
                assign status[i] = ~last_msb;
            end else if (i == TGL_BIT) begin : g_tgl
                assign status[i] = toggle;
            end else begin : g_rsv
                assign status[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        dq_oe = rd_sel;
        if (!rd_sel)     dq_out = '0;
        else if (busy)   dq_out = status;
        else             dq_out = arr_rdata;
    end
endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp
    import sp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic       rd_sel;
    logic       toggle_q;
    acc_state_t acc_state;

    sp_strobe u_strobe (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .rd_sel (rd_sel)
    );

    sp_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rd_sel),
        .busy     (busy),
        .state_q  (acc_state),
        .toggle_q (toggle_q)
    );

    sp_out_mux #(.DATA_W(DATA_W)) u_mux (
        .rd_sel    (rd_sel),
        .busy      (busy),
        .toggle    (toggle_q),
        .last_msb  (last_msb),
        .arr_rdata (arr_rdata),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );
endmodule

// File: rtl/wr_status_resp_chk.sv
module wr_status_resp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              busy,
    input logic              last_msb,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);
    localparam int PB = DATA_W - 1;
    localparam int TB = DATA_W - 2;

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == '0));

    assert_poll_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy) |-> (dq_out[PB] == ~last_msb));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy) |-> (dq_out[TB-1:0] == '0));

    assert_array_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !busy) |-> (dq_out == arr_rdata));

    assert_toggle_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy && $past(rst_n) && $past(dq_oe && busy))
        |-> (dq_out[TB] == $past(dq_out[TB])));
endmodule

bind wr_status_resp wr_status_resp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .busy      (busy),
    .last_msb  (last_msb),
    .arr_rdata (arr_rdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/tb_wr_status_resp.sv
module tb_wr_status_resp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       busy = 1'b0;
    logic       last_msb = 1'b0;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic exp_tgl = 1'b0;

    always #5 clk = ~clk;

    wr_status_resp #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
        .last_msb(last_msb), .arr_rdata(arr_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] stat(input logic msb, input logic t);
        return {~msb, t, 6'b0};
    endfunction

    task automatic busy_read(input logic msb, input string tag);
        @(negedge clk);
        busy = 1'b1; last_msb = msb; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(tag, dq_out, stat(msb, exp_tgl));
        chk({tag, " oe R1"}, {7'b0, dq_oe}, 8'h01);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        exp_tgl = ~exp_tgl;
    endtask

    task automatic array_read(input logic [7:0] d, input string tag);
        @(negedge clk);
        busy = 1'b0; arr_rdata = d; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(tag, dq_out, d);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("reset bus idle R1", {dq_oe, 7'b0} | dq_out, 8'h00);

        // R7: first busy read after reset shows bit 6 = 0
        busy_read(1'b0, "first poll R7 R2 R3 R4");

        // R2 R3 R4: alternating bit and inverse across many busy reads
        for (int i = 0; i < 64; i++)
            busy_read(i[0] ^ i[3], "poll sweep R2 R3 R4");

        // R5 R8: full sweep of array words while not busy, toggle untouched
        for (int v = 0; v < 256; v++)
            array_read(v[7:0], "array sweep R5 R8");
        busy_read(1'b1, "toggle after array reads R8 R3");

        // R1: all strobe combinations, busy low and high
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                busy = b[0]; last_msb = 1'b1; arr_rdata = 8'h5A;
                ce_n = s[1]; oe_n = s[0];
                #1;
                if (s == 0) begin
                    chk("strobes low R1", {7'b0, dq_oe},  8'h01);
                    chk("strobes low data R1", dq_out,
                        b[0] ? stat(1'b1, exp_tgl) : 8'h5A);
                end else begin
                    chk("strobe high R1", {7'b0, dq_oe}, 8'h00);
                    chk("strobe high data R1", dq_out, 8'h00);
                end
                @(negedge clk);
                ce_n = 1'b1; oe_n = 1'b1;
                @(negedge clk);
                if (s == 0 && b == 1) exp_tgl = ~exp_tgl;
            end
        end

        // R9: long held busy read keeps bit 6 constant
        @(negedge clk);
        busy = 1'b1; last_msb = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            #1;
            chk("held read R9", dq_out, stat(1'b0, exp_tgl));
            @(negedge clk);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        exp_tgl = ~exp_tgl;
        busy_read(1'b0, "after held read R9 R3");

        // R6: busy released mid-read, array data same cycle, no toggle
        @(negedge clk);
        busy = 1'b1; last_msb = 1'b1; arr_rdata = 8'hC3; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("before release R6", dq_out, stat(1'b1, exp_tgl));
        @(negedge clk);
        busy = 1'b0;
        #1;
        chk("busy released R6", dq_out, 8'hC3);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        busy_read(1'b1, "toggle kept after release R6");

        // R8: refused write leaves busy low, read returns array data
        array_read(8'h81, "refused write no status R8");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule